// File: doc/BRIEF.md
# Character-Unit Address Generator

This block turns a base register, a displacement and an index into the place in memory where a data unit lives. The unit is a byte, a 6-bit character or a 12-bit storage unit. The five low bits of the base register hold a mode code. A code of zero means plain byte addressing. The other legal codes say which unit size the displacement and index count in, and how characters are packed into 256-bit memory blocks, skipping any pad bits.

The result has two parts. The first is the byte address of the 256-bit block that holds the unit. The second is the bit offset of the unit's first bit inside that block, counted from the most significant end, since memory is big-endian.

Requests enter and results leave on valid/ready streams. A request moves into the block when `in_valid` and `in_ready` are both high at a clock edge. A result is taken when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result is held unchanged. Once the internal stages are full, `in_ready` drops. A request that is not accepted may be held or changed by the source.

Top module: `cua_addr_gen`

## Requirements
- R1: The mode code is `in_base[4:0]`. Codes 1, 2 and 3 count in 12-bit units, and each unit is treated as two 6-bit characters. Codes 5, 6 and 7 count in 6-bit characters. The packing is chosen by code bits [1:0] (1, 2 or 3). Every code other than 0, 1, 2, 3, 5, 6 and 7 sets `out_err` to 1 and gives a block address and bit offset of zero.
- R2: With code 0, the byte address is base + displacement + index. `out_blk_addr` is that byte address with its low 5 bits cleared. `out_bit_off` is 8 times its low 5 bits.
- R3: In the converting modes, the unit offset is displacement + index. Both are unsigned, and the sum is formed at full width with no wrap.
- R4: In the converting modes, the block base is the base register with its low 8 bits cleared. Base bits [7:5] have no effect.
- R5: Packing 1 joins three consecutive blocks into a group of 128 characters with no pad. Character k of a group starts at bit 6k of the group. The result is block 3·group + ⌊6k/256⌋, at bit offset 6k mod 256.
- R6: Packing 2 puts 42 characters in each block after 4 pad bits. Character r of a block starts at bit 4 + 6r.
- R7: Packing 3 splits each block into four 64-bit doublewords. Each doubleword holds 4 pad bits and then 10 characters. Character r of a block starts at bit 64·⌊r/10⌋ + 4 + 6·(r mod 10).
- R8: In the converting modes, `out_blk_addr` equals the block base plus 32 times the block number.
- R9: A result appears two clock edges after the edge that accepts its request, and results leave in order. While `out_valid` is high and `out_ready` is low, the outputs stay stable. `in_ready` is low only when all three stages hold data and the output is stalled.
- R10: During and right after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_base | input | ADDR_W (64) | Base register; low 5 bits are the mode code |
| in_disp | input | DISP_W (16) | Unsigned displacement in selected units |
| in_index | input | IDX_W (32) | Unsigned index in selected units |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_blk_addr | output | ADDR_W (64) | Byte address of the 256-bit block |
| out_bit_off | output | 8 | Bit offset of the unit within the block |
| out_err | output | 1 | Unsupported mode code |

## Verification
The assertions assume that the consumer drives `out_ready` to a known value on every cycle. They also assume that a remainder reaching the last stage always comes from a legal packing code, so it is below that packing's units-per-block count. The stimulus respects both assumptions. It keeps `out_ready` driven at all times and sends mode codes only through the normal request port. The index and displacement values used include the widest possible sum, so the remainder checks are exercised near the top of the input range.

// File: rtl/cua_pkg.sv
package cua_pkg;
  typedef enum logic [2:0] {
    K_BYTE = 3'd0,
    K_P1   = 3'd1,
    K_P2   = 3'd2,
    K_P3   = 3'd3,
    K_BAD  = 3'd4
  } cua_kind_e;

  localparam int BLK_BITS  = 256;
  localparam int CHAR_BITS = 6;
  localparam int PAD_BITS  = 4;
  localparam int DW_BITS   = 64;
  // characters per three-block group, per padded block, per padded doubleword
  localparam int P1_CHARS  = (3 * BLK_BITS) / CHAR_BITS;
  localparam int P2_CHARS  = (BLK_BITS - PAD_BITS) / CHAR_BITS;
  localparam int DW_CHARS  = (DW_BITS - PAD_BITS) / CHAR_BITS;
  localparam int P3_CHARS  = (BLK_BITS / DW_BITS) * DW_CHARS;
endpackage

// File: rtl/cua_decode.sv
module cua_decode
  import cua_pkg::*;
#(
  parameter int DISP_W = 16,
  parameter int IDX_W  = 32,
  parameter int SUM_W  = 33,
  parameter int VAL_W  = 34
) (
  input  logic [4:0]        code,
  input  logic [DISP_W-1:0] disp,
  input  logic [IDX_W-1:0]  idx,
  output cua_kind_e         kind,
  output logic [VAL_W-1:0]  val
);
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum  = SUM_W'(disp) + SUM_W'(idx);
    kind = K_BAD;
    val  = VAL_W'(sum);
    if (code == 5'd0) begin
      kind = K_BYTE;
    end else if (code[4:3] == 2'b00 && code[1:0] != 2'b00) begin
      case (code[1:0])
        2'd1:    kind = K_P1;
        2'd2:    kind = K_P2;
        default: kind = K_P3;
      endcase
      // a 12-bit unit spans two characters
      if (!code[2]) val = {sum, 1'b0};
    end
  end
endmodule

// File: rtl/cua_split.sv
module cua_split
  import cua_pkg::*;
#(
  parameter int VAL_W = 34,
  parameter int R_W   = 7
) (
  input  cua_kind_e        kind,
  input  logic [VAL_W-1:0] val,
  output logic [VAL_W-1:0] quo,
  output logic [R_W-1:0]   rem
);
  localparam logic [VAL_W-1:0] DIV1 = VAL_W'(P1_CHARS);
  localparam logic [VAL_W-1:0] DIV2 = VAL_W'(P2_CHARS);
  localparam logic [VAL_W-1:0] DIV3 = VAL_W'(P3_CHARS);

  always_comb begin
    quo = val;
    rem = '0;
    case (kind)
      K_P1: begin quo = val / DIV1; rem = R_W'(val % DIV1); end
      K_P2: begin quo = val / DIV2; rem = R_W'(val % DIV2); end
      K_P3: begin quo = val / DIV3; rem = R_W'(val % DIV3); end
      default: ;
    endcase
  end
endmodule

// File: rtl/cua_place.sv
module cua_place
  import cua_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int VAL_W  = 34,
  parameter int R_W    = 7
) (
  input  cua_kind_e         kind,
  input  logic [ADDR_W-1:0] base,
  input  logic [VAL_W-1:0]  quo,
  input  logic [R_W-1:0]    rem,
  output logic [ADDR_W-1:0] blk,
  output logic [7:0]        bitoff,
  output logic              err
);
  localparam int BLK_LG = 5; // 32 bytes per block
  logic [ADDR_W-1:0] byte_addr, blk_base, nblk;
  logic [9:0]        gbit;
  logic [1:0]        dw;
  logic [R_W-1:0]    wc;

  always_comb begin
    byte_addr = base + ADDR_W'(quo);
    blk_base  = {base[ADDR_W-1:8], 8'h00};
    gbit      = 10'(rem) * 10'd6;
    dw        = 2'(rem / R_W'(DW_CHARS));
    wc        = rem % R_W'(DW_CHARS);
    nblk      = ADDR_W'(quo);
    blk       = '0;
    bitoff    = '0;
    err       = 1'b0;
    case (kind)
      K_BYTE: begin
        blk    = {byte_addr[ADDR_W-1:BLK_LG], {BLK_LG{1'b0}}};
        bitoff = {byte_addr[BLK_LG-1:0], 3'b000};
      end
      K_P1: begin
        nblk   = ADDR_W'(quo) * ADDR_W'(3) + ADDR_W'(gbit[9:8]);
        bitoff = gbit[7:0];
        blk    = blk_base + (nblk << BLK_LG);
      end
      K_P2: begin
        bitoff = 8'(PAD_BITS) + gbit[7:0];
        blk    = blk_base + (nblk << BLK_LG);
      end
      K_P3: begin
        bitoff = {dw, 6'b000000} + 8'(PAD_BITS) + 8'(wc * R_W'(CHAR_BITS));
        blk    = blk_base + (nblk << BLK_LG);
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/cua_addr_gen.sv
module cua_addr_gen
  import cua_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DISP_W = 16,
  parameter int IDX_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [DISP_W-1:0] in_disp,
  input  logic [IDX_W-1:0]  in_index,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_blk_addr,
  output logic [7:0]        out_bit_off,
  output logic              out_err
);
  localparam int SUM_W = ((DISP_W > IDX_W) ? DISP_W : IDX_W) + 1;
  localparam int VAL_W = SUM_W + 1;
  localparam int R_W   = 7;

  // stage enables, back to front
  logic en1, en2, en3;
  assign en3      = !out_valid || out_ready;
  assign en2      = !v2 || en3;
  assign en1      = !v1 || en2;
  assign in_ready = en1;

  // stage 1: decode and unit sum
  cua_kind_e         d_kind;
  logic [VAL_W-1:0]  d_val;
  logic              v1;
  cua_kind_e         s1_kind;
  logic [VAL_W-1:0]  s1_val;
  logic [ADDR_W-1:0] s1_base;

  cua_decode #(.DISP_W(DISP_W), .IDX_W(IDX_W), .SUM_W(SUM_W), .VAL_W(VAL_W)) u_dec (
    .code(in_base[4:0]), .disp(in_disp), .idx(in_index), .kind(d_kind), .val(d_val));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; s1_kind <= K_BYTE; s1_val <= '0; s1_base <= '0;
    end else if (en1) begin
      v1 <= in_valid;
      if (in_valid) begin
        s1_kind <= d_kind; s1_val <= d_val; s1_base <= in_base;
      end
    end
  end

  // stage 2: block number and remainder
  logic [VAL_W-1:0]  q_c;
  logic [R_W-1:0]    r_c;
  logic              v2;
  cua_kind_e         s2_kind;
  logic [VAL_W-1:0]  s2_quo;
  logic [R_W-1:0]    s2_rem;
  logic [ADDR_W-1:0] s2_base;

  cua_split #(.VAL_W(VAL_W), .R_W(R_W)) u_split (
    .kind(s1_kind), .val(s1_val), .quo(q_c), .rem(r_c));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; s2_kind <= K_BYTE; s2_quo <= '0; s2_rem <= '0; s2_base <= '0;
    end else if (en2) begin
      v2 <= v1;
      if (v1) begin
        s2_kind <= s1_kind; s2_quo <= q_c; s2_rem <= r_c; s2_base <= s1_base;
      end
    end
  end

  // stage 3: bit placement, registered outputs
  logic [ADDR_W-1:0] p_blk;
  logic [7:0]        p_bit;
  logic              p_err;

  cua_place #(.ADDR_W(ADDR_W), .VAL_W(VAL_W), .R_W(R_W)) u_place (
    .kind(s2_kind), .base(s2_base), .quo(s2_quo), .rem(s2_rem),
    .blk(p_blk), .bitoff(p_bit), .err(p_err));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_blk_addr <= '0; out_bit_off <= '0; out_err <= 1'b0;
    end else if (en3) begin
      out_valid <= v2;
      if (v2) begin
        out_blk_addr <= p_blk; out_bit_off <= p_bit; out_err <= p_err;
      end
    end
  end

  // remainders leaving the divider stay inside the block's character count
  assert_rem_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && s2_kind == K_P2) |-> (s2_rem < R_W'(P2_CHARS)));
  assert_rem_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && s2_kind == K_P3) |-> (s2_rem < R_W'(P3_CHARS)));
  // character starts are even bit positions in every packing
  assert_even_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && s2_kind != K_BYTE && s2_kind != K_BAD && en3) |=> !out_bit_off[0]);
  assert_err_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_blk_addr == '0 && out_bit_off == 8'd0));
  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_blk_addr)
                                   && $stable(out_bit_off) && $stable(out_err)));
  assert_ready_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (v1 && v2 && out_valid && !out_ready));
endmodule

// File: tb/tb_cua_addr_gen.sv
module tb_cua_addr_gen;
  localparam time PERIOD = 10;

  typedef struct packed {
    logic [63:0] base;
    logic [15:0] disp;
    logic [31:0] idx;
    logic [63:0] blk;
    logic [7:0]  boff;
    logic        err;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{64'h1000, 16'd3,      32'h25,       64'h1020,     8'd64,  1'b0, 4'd2}, // R2 byte mode
    '{64'h1007, 16'd0,      32'd0,        64'h1000,     8'd4,   1'b0, 4'd7}, // R7 first char
    '{64'h1007, 16'd13,     32'd0,        64'h1000,     8'd86,  1'b0, 4'd7}, // R7 second doubleword
    '{64'h1007, 16'd40,     32'd45,       64'h1040,     8'd34,  1'b0, 4'd8}, // R8 block 2
    '{64'h1006, 16'd41,     32'd0,        64'h1000,     8'd250, 1'b0, 4'd6}, // R6 last char
    '{64'h1006, 16'd2,      32'd40,       64'h1020,     8'd4,   1'b0, 4'd6}, // R6 wrap to next block
    '{64'h1005, 16'd42,     32'd0,        64'h1000,     8'd252, 1'b0, 4'd5}, // R5 end of block 0
    '{64'h1005, 16'd43,     32'd0,        64'h1020,     8'd2,   1'b0, 4'd5}, // R5 straddle
    '{64'h1005, 16'd100,    32'd200,      64'h10E0,     8'd8,   1'b0, 4'd5}, // R5 group 2
    '{64'h1001, 16'd64,     32'd0,        64'h1060,     8'd0,   1'b0, 4'd1}, // R1 12-bit, packing 1
    '{64'h1002, 16'd21,     32'd0,        64'h1020,     8'd4,   1'b0, 4'd1}, // R1 12-bit, packing 2
    '{64'h1003, 16'd5,      32'd0,        64'h1000,     8'd68,  1'b0, 4'd1}, // R1 12-bit, packing 3
    '{64'h1004, 16'd9,      32'd9,        64'h0,        8'd0,   1'b1, 4'd1}, // R1 code 4 rejected
    '{64'h1010, 16'd0,      32'd0,        64'h0,        8'd0,   1'b1, 4'd1}, // R1 code 16 rejected
    '{64'h10E7, 16'd0,      32'd0,        64'h1000,     8'd4,   1'b0, 4'd4}, // R4 base bits 7:5 masked
    '{64'h1006, 16'hFFFF,   32'hFFFFFFFF, 64'hC30D03C0, 8'd112, 1'b0, 4'd3}  // R3 full-width sum
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_base = '0;
  logic [15:0] in_disp = '0;
  logic [31:0] in_index = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_blk_addr;
  logic [7:0]  out_bit_off;
  logic        out_err;

  int n_run = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  cua_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_disp(in_disp), .in_index(in_index),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_blk_addr(out_blk_addr), .out_bit_off(out_bit_off), .out_err(out_err));

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input logic ok, input string rq, input logic [79:0] act, input logic [79:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk_out(input string rq, input logic [63:0] eb, input logic [7:0] eo, input logic ee);
    logic [79:0] a, e;
    a = {7'd0, out_blk_addr, out_bit_off, out_err};
    e = {7'd0, eb, eo, ee};
    chk(out_valid && a == e, rq, a, e);
  endtask

  task automatic send(input logic [63:0] b, input logic [15:0] d, input logic [31:0] x);
    @(negedge clk);
    in_base = b; in_disp = d; in_index = x; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: idle and ready after reset
    chk(!out_valid && in_ready, "R10", {78'd0, out_valid, in_ready}, 80'd1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      send(VT[i].base, VT[i].disp, VT[i].idx);
      @(negedge clk);
      while (!out_valid) @(negedge clk);
      chk_out(rname(VT[i].rq), VT[i].blk, VT[i].boff, VT[i].err);
    end

    // R9 latency: result two edges after the accepting edge
    send(64'h1006, 16'd1, 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk(!out_valid, "R9", {79'd0, out_valid}, 80'd0);
    @(negedge clk);
    chk_out("R9", 64'h1000, 8'd10, 1'b0);

    // R9 back-pressure: fill the stages with the output stalled
    @(negedge clk);
    out_ready = 1'b0;
    send(64'h1007, 16'd0, 32'd0);
    send(64'h1007, 16'd1, 32'd0);
    send(64'h1007, 16'd2, 32'd0);
    repeat (3) @(negedge clk);
    in_base = 64'h1007; in_disp = 16'd3; in_index = 32'd0; in_valid = 1'b1;
    #1;
    chk(!in_ready, "R9", {79'd0, in_ready}, 80'd0);
    chk_out("R9", 64'h1000, 8'd4, 1'b0);
    repeat (2) @(negedge clk);
    chk_out("R9", 64'h1000, 8'd4, 1'b0); // held while stalled
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk_out("R9", 64'h1000, 8'd10, 1'b0);
    @(negedge clk);
    chk_out("R9", 64'h1000, 8'd16, 1'b0);
    @(negedge clk);
    chk_out("R9", 64'h1000, 8'd22, 1'b0);
    @(negedge clk);
    chk(!out_valid, "R9", {79'd0, out_valid}, 80'd0);

    // R10: reset in the middle of traffic empties the pipe
    send(64'h1000, 16'd0, 32'd0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!out_valid && in_ready, "R10", {78'd0, out_valid, in_ready}, 80'd1);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule